// File: doc/BRIEF.md
# Wrapping Command-Queue Fetch Sequencer

This block moves pending command packets from a circular queue in host memory into a local packet ring. A fetch is triggered by a request pulse, or automatically when the local ring retires entries. The block first works out how many packets are waiting, then asks the local ring for that many slots. The host read index moves forward at once by the number of slots granted. The granted packets are then copied with a series of DMA read bursts.

A burst never runs past the wrap point of either ring. Its length is the smallest of four limits: host entries left before the host wrap, local slots left before the local wrap, packets still pending, and slots still granted.

Only one fetch series can be in flight at a time. A series counter starts at the granted total and is decremented as each burst's data returns. When it reaches zero, the block pulses a wake signal for the dispatcher. A short grant raises a stall flag. Later retirements in the local ring use that flag to restart fetching. Each retirement also writes the new local read index back to the host with a single DMA write.

Top module: `cqf_fetch_seq`

## Requirements
- R1: After reset, `rd_valid`, `alloc_req`, `wb_valid`, `done_wake` and `stalled` are low and `host_rd_idx` is zero.
- R2: The pending count is `host_wr_idx - host_rd_idx` modulo 2^IW. When it is zero, a fetch trigger is consumed without raising `alloc_req`.
- R3: `alloc_req` is high for exactly one cycle and `alloc_cnt` equals the pending count. The block samples `alloc_grant` (at most `alloc_cnt`) and `alloc_wr_slot` in that same cycle. From the next cycle, `host_rd_idx` has advanced by the grant.
- R4: The first burst's local slot is `(alloc_wr_slot - alloc_grant) mod LDEPTH`. Here `alloc_wr_slot` is the local write position after the allocation.
- R5: Each burst length is the minimum of: `2^host_log2 - hs`, `LDEPTH - local slot`, remaining pending, and remaining granted. Here `hs = host position mod 2^host_log2`. The burst carries `rd_host_addr = host_base + hs*PKT_BYTES`. Both positions then advance modulo their depths, and bursts are issued in order.
- R6: A zero grant sets `stalled` and issues no burst. A non-zero grant clears `stalled`. If the grant is smaller than the pending count, `stalled` is set when the last burst is accepted.
- R7: `rsp_valid` retires the oldest outstanding burst. `done_wake` pulses for one cycle, in the cycle after the response that completes the whole granted total, and at no other time.
- R8: A fetch request that arrives while a series is in progress starts nothing immediately. It is held, and one fetch starts after the series completes.
- R9: A retirement pulse (`local_rd_adv`) while `stalled` is set starts a new fetch without any fetch request.
- R10: A retirement pulse raises `wb_valid` in the next cycle, with `wb_data` set to `local_rd_new` and `wb_addr` set to `rdptr_addr`. `wb_valid` and `wb_data` hold until `wb_ready`.
- R11: A retirement pulse while `host_wr_idx` differs from `host_rd_idx` starts a new fetch. When the two are equal and the block is not stalled, a retirement starts nothing.
- R12: While `rd_valid` is high and `rd_ready` is low, the burst fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch trigger pulse |
| host_wr_idx | input | IW | Host queue write index |
| host_log2 | input | HLW | log2 of host queue depth |
| host_base | input | AW | Host queue base address |
| rdptr_addr | input | AW | Host location of the read pointer |
| alloc_req | output | 1 | Local ring allocation request |
| alloc_cnt | output | IW | Slots requested |
| alloc_grant | input | IW | Slots granted (same cycle) |
| alloc_wr_slot | input | LAW | Local write slot after allocation |
| rd_valid | output | 1 | DMA read burst request valid |
| rd_ready | input | 1 | DMA read burst accepted |
| rd_host_addr | output | AW | Burst source address |
| rd_slot | output | LAW | Burst destination slot |
| rd_len | output | IW | Burst length in packets |
| rsp_valid | input | 1 | Oldest burst's data has landed |
| done_wake | output | 1 | Series complete, wake dispatcher |
| stalled | output | 1 | Stalled on local ring space |
| host_rd_idx | output | IW | Host queue read index |
| local_rd_adv | input | 1 | Local ring retired entries |
| local_rd_new | input | IW | New local read index |
| wb_valid | output | 1 | Read-index write-back valid |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | AW | Write-back address |
| wb_data | output | IW | Write-back data |

## Verification
The bench builds the block with an 8-slot local ring and 64-byte packets. At run time it picks host depths of 4, 8 and 16. With these values, a single series can hit a host wrap, a local wrap or both, which brings the three-burst split within reach. Grants capped below the pending count or at zero exercise the stall and retire-driven restart. A 16-bit index lets the free-running indices pass many ring laps in a short run.

// File: rtl/cqf_pkg.sv
package cqf_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ALLOC = 2'd1,
      ST_ISSUE = 2'd2
   } cqf_state_e;
endpackage

// File: rtl/cqf_burst_sizer.sv
module cqf_burst_sizer #(
   parameter int IW      = 16,
   parameter int LDEPTH  = 8,
   parameter int HMAXLOG = 8,
   localparam int LAW    = $clog2(LDEPTH),
   localparam int HLW    = $clog2(HMAXLOG + 1)
) (
   input  logic [IW-1:0]  host_pos,
   input  logic [HLW-1:0] host_log2,
   input  logic [LAW-1:0] local_slot,
   input  logic [IW-1:0]  rem_pend,
   input  logic [IW-1:0]  rem_grant,
   output logic [IW-1:0]  host_slot,
   output logic [IW-1:0]  burst_len
);
   localparam int NLIM = 4;

   logic [IW-1:0] hdepth;
   logic [IW-1:0] limit [NLIM];
   logic [IW-1:0] best  [NLIM+1];

   assign hdepth    = IW'(1) << host_log2;
   assign host_slot = host_pos & (hdepth - IW'(1));

   assign limit[0] = hdepth - host_slot;
   assign limit[1] = IW'(LDEPTH) - IW'(local_slot);
   assign limit[2] = rem_pend;
   assign limit[3] = rem_grant;

   assign best[0] = '1;
   for (genvar k = 0; k < NLIM; k++) begin : g_min
      assign best[k+1] = (limit[k] < best[k]) ? limit[k] : best[k];
   end

   assign burst_len = best[NLIM];
endmodule

// File: rtl/cqf_len_fifo.sv
module cqf_len_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   logic [W-1:0]  slot_q [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [PW:0]   cnt_q;
   logic          do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == (PW+1)'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = slot_q[rp_q];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)                                slot_q[i] <= '0;
         else if (do_push && wp_q == PW'(i))        slot_q[i] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + PW'(1);
         if (do_pop)  rp_q <= (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + PW'(1);
         cnt_q <= cnt_q + (PW+1)'(do_push) - (PW+1)'(do_pop);
      end
   end
endmodule

// File: rtl/cqf_rdidx_wb.sv
module cqf_rdidx_wb #(
   parameter int IW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          retire,
   input  logic [IW-1:0] new_idx,
   input  logic          wb_ready,
   output logic          wb_valid,
   output logic [IW-1:0] wb_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_valid <= 1'b0;
         wb_data  <= '0;
      end else if (retire) begin
         wb_valid <= 1'b1;
         wb_data  <= new_idx;
      end else if (wb_valid && wb_ready) begin
         wb_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/cqf_fetch_seq.sv
module cqf_fetch_seq #(
   parameter int IW        = 16,
   parameter int AW        = 32,
   parameter int LDEPTH    = 8,
   parameter int HMAXLOG   = 8,
   parameter int PKT_BYTES = 64,
   parameter int LFIFO     = 4,
   localparam int LAW      = $clog2(LDEPTH),
   localparam int HLW      = $clog2(HMAXLOG + 1),
   localparam int PKT_SH   = $clog2(PKT_BYTES)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           fetch_req,
   input  logic [IW-1:0]  host_wr_idx,
   input  logic [HLW-1:0] host_log2,
   input  logic [AW-1:0]  host_base,
   input  logic [AW-1:0]  rdptr_addr,
   output logic           alloc_req,
   output logic [IW-1:0]  alloc_cnt,
   input  logic [IW-1:0]  alloc_grant,
   input  logic [LAW-1:0] alloc_wr_slot,
   output logic           rd_valid,
   input  logic           rd_ready,
   output logic [AW-1:0]  rd_host_addr,
   output logic [LAW-1:0] rd_slot,
   output logic [IW-1:0]  rd_len,
   input  logic           rsp_valid,
   output logic           done_wake,
   output logic           stalled,
   output logic [IW-1:0]  host_rd_idx,
   input  logic           local_rd_adv,
   input  logic [IW-1:0]  local_rd_new,
   output logic           wb_valid,
   input  logic           wb_ready,
   output logic [AW-1:0]  wb_addr,
   output logic [IW-1:0]  wb_data
);
   import cqf_pkg::*;

   if (LDEPTH < 2 || (LDEPTH & (LDEPTH - 1)) != 0) begin : g_bad_ldepth
      initial $fatal(1, "LDEPTH must be a power of two >= 2");
   end
   if (HMAXLOG >= IW || LDEPTH >= (1 << (IW - 1))) begin : g_bad_iw
      initial $fatal(1, "IW too narrow for ring depths");
   end
   if ((PKT_BYTES & (PKT_BYTES - 1)) != 0) begin : g_bad_pkt
      initial $fatal(1, "PKT_BYTES must be a power of two");
   end
   if (LFIFO < 1) begin : g_bad_fifo
      initial $fatal(1, "LFIFO must be at least 1");
   end

   cqf_state_e    st_q;
   logic          kick_q;
   logic [IW-1:0] pend_q, hrd_q, hpos_q, rpend_q, rgrant_q, series_q;
   logic [LAW-1:0] lslot_q;
   logic          stall_q, wake_q;

   logic          busy, trig, consume, fire, pop;
   logic [IW-1:0] pending, blen, hslot, head_len;
   logic          fifo_empty, fifo_full;

   assign busy    = (st_q != ST_IDLE) || (series_q != '0);
   assign pending = host_wr_idx - hrd_q;
   assign trig    = fetch_req ||
                    (local_rd_adv && (stall_q || (host_wr_idx != hrd_q)));
   assign consume = (st_q == ST_IDLE) && kick_q && !busy;
   assign fire    = rd_valid && rd_ready;
   assign pop     = rsp_valid && !fifo_empty;

   cqf_burst_sizer #(.IW(IW), .LDEPTH(LDEPTH), .HMAXLOG(HMAXLOG)) u_sizer (
      .host_pos   (hpos_q),
      .host_log2  (host_log2),
      .local_slot (lslot_q),
      .rem_pend   (rpend_q),
      .rem_grant  (rgrant_q),
      .host_slot  (hslot),
      .burst_len  (blen)
   );

   cqf_len_fifo #(.W(IW), .DEPTH(LFIFO)) u_lenq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (fire),
      .push_data (blen),
      .pop       (pop),
      .head      (head_len),
      .empty     (fifo_empty),
      .full      (fifo_full)
   );

   cqf_rdidx_wb #(.IW(IW)) u_wb (
      .clk      (clk),
      .rst_n    (rst_n),
      .retire   (local_rd_adv),
      .new_idx  (local_rd_new),
      .wb_ready (wb_ready),
      .wb_valid (wb_valid),
      .wb_data  (wb_data)
   );

   assign alloc_req    = (st_q == ST_ALLOC);
   assign alloc_cnt    = pend_q;
   assign rd_valid     = (st_q == ST_ISSUE) && !fifo_full;
   assign rd_slot      = lslot_q;
   assign rd_len       = blen;
   assign rd_host_addr = host_base + (AW'(hslot) << PKT_SH);
   assign done_wake    = wake_q;
   assign stalled      = stall_q;
   assign host_rd_idx  = hrd_q;
   assign wb_addr      = rdptr_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         kick_q   <= 1'b0;
         pend_q   <= '0;
         hrd_q    <= '0;
         hpos_q   <= '0;
         lslot_q  <= '0;
         rpend_q  <= '0;
         rgrant_q <= '0;
         series_q <= '0;
         stall_q  <= 1'b0;
         wake_q   <= 1'b0;
      end else begin
         kick_q <= trig || (kick_q && !consume);
         wake_q <= pop && (series_q == head_len);

         if (st_q == ST_ALLOC && alloc_grant != '0) series_q <= alloc_grant;
         else if (pop)                               series_q <= series_q - head_len;

         unique case (st_q)
            ST_IDLE: begin
               if (consume && pending != '0) begin
                  pend_q <= pending;
                  st_q   <= ST_ALLOC;
               end
            end
            ST_ALLOC: begin
               if (alloc_grant == '0) begin
                  stall_q <= 1'b1;
                  st_q    <= ST_IDLE;
               end else begin
                  stall_q  <= 1'b0;
                  hpos_q   <= hrd_q;
                  hrd_q    <= hrd_q + alloc_grant;
                  lslot_q  <= alloc_wr_slot - LAW'(alloc_grant);
                  rpend_q  <= pend_q;
                  rgrant_q <= alloc_grant;
                  st_q     <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (fire) begin
                  hpos_q   <= hpos_q + blen;
                  lslot_q  <= lslot_q + LAW'(blen);
                  rpend_q  <= rpend_q - blen;
                  rgrant_q <= rgrant_q - blen;
                  if (rgrant_q == blen) begin
                     st_q <= ST_IDLE;
                     if (rpend_q != blen) stall_q <= 1'b1;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cqf_fetch_seq_chk.sv
module cqf_fetch_seq_chk #(
   parameter int IW     = 16,
   parameter int AW     = 32,
   parameter int LDEPTH = 8,
   localparam int LAW   = $clog2(LDEPTH)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           alloc_req,
   input logic [IW-1:0]  alloc_cnt,
   input logic           rd_valid,
   input logic           rd_ready,
   input logic [AW-1:0]  rd_host_addr,
   input logic [LAW-1:0] rd_slot,
   input logic [IW-1:0]  rd_len,
   input logic           rsp_valid,
   input logic           done_wake,
   input logic           stalled,
   input logic [IW-1:0]  host_rd_idx,
   input logic           local_rd_adv,
   input logic           wb_valid,
   input logic           wb_ready,
   input logic [IW-1:0]  wb_data
);
   p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_len) &&
                                $stable(rd_slot) && $stable(rd_host_addr));

   p_len_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_len != '0) &&
                   ((IW+1)'(rd_slot) + (IW+1)'(rd_len) <= (IW+1)'(LDEPTH)));

   p_alloc_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_req |-> alloc_cnt != '0);

   p_wake_after_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_wake |-> $past(rsp_valid));

   p_wb_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid && !wb_ready && !local_rd_adv |=> wb_valid && $stable(wb_data));

   p_stall_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stalled) |-> $past(alloc_req) || $past(rd_valid && rd_ready));

   p_rdidx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(host_rd_idx) |-> $past(alloc_req));
endmodule

bind cqf_fetch_seq cqf_fetch_seq_chk #(.IW(IW), .AW(AW), .LDEPTH(LDEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .alloc_req    (alloc_req),
   .alloc_cnt    (alloc_cnt),
   .rd_valid     (rd_valid),
   .rd_ready     (rd_ready),
   .rd_host_addr (rd_host_addr),
   .rd_slot      (rd_slot),
   .rd_len       (rd_len),
   .rsp_valid    (rsp_valid),
   .done_wake    (done_wake),
   .stalled      (stalled),
   .host_rd_idx  (host_rd_idx),
   .local_rd_adv (local_rd_adv),
   .wb_valid     (wb_valid),
   .wb_ready     (wb_ready),
   .wb_data      (wb_data)
);

// File: tb/cqf_fetch_seq_bench.sv
module cqf_fetch_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int IW = 16, AW = 32, LDEPTH = 8, HMAXLOG = 8, PKT_BYTES = 64;
   localparam int LAW = $clog2(LDEPTH);
   localparam int HLW = $clog2(HMAXLOG + 1);
   localparam logic [AW-1:0] BASE  = 32'h4000_0000;
   localparam logic [AW-1:0] RDPTR = 32'h0000_8800;

   logic clk = 1'b0, rst_n = 1'b0;
   logic fetch_req = 1'b0, rd_ready = 1'b0, rsp_valid = 1'b0;
   logic local_rd_adv = 1'b0, wb_ready = 1'b1;
   logic [IW-1:0] host_wr_idx = '0, alloc_grant = '0, local_rd_new = '0;
   logic [HLW-1:0] host_log2 = HLW'(2);
   logic [LAW-1:0] alloc_wr_slot = '0;
   logic alloc_req, rd_valid, done_wake, stalled, wb_valid;
   logic [IW-1:0] alloc_cnt, rd_len, host_rd_idx, wb_data;
   logic [AW-1:0] rd_host_addr, wb_addr;
   logic [LAW-1:0] rd_slot;

   always #(CLK_PERIOD/2) clk = ~clk;

   cqf_fetch_seq #(.IW(IW), .AW(AW), .LDEPTH(LDEPTH), .HMAXLOG(HMAXLOG),
                   .PKT_BYTES(PKT_BYTES), .LFIFO(4)) u_cqf_fetch_seq (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .host_wr_idx(host_wr_idx),
      .host_log2(host_log2), .host_base(BASE), .rdptr_addr(RDPTR),
      .alloc_req(alloc_req), .alloc_cnt(alloc_cnt), .alloc_grant(alloc_grant),
      .alloc_wr_slot(alloc_wr_slot), .rd_valid(rd_valid), .rd_ready(rd_ready),
      .rd_host_addr(rd_host_addr), .rd_slot(rd_slot), .rd_len(rd_len),
      .rsp_valid(rsp_valid), .done_wake(done_wake), .stalled(stalled),
      .host_rd_idx(host_rd_idx), .local_rd_adv(local_rd_adv),
      .local_rd_new(local_rd_new), .wb_valid(wb_valid), .wb_ready(wb_ready),
      .wb_addr(wb_addr), .wb_data(wb_data)
   );

   int checks = 0, errors = 0;
   logic [IW-1:0] m_hrd = '0, m_lwr = '0, m_lrd = '0;
   int g_pend, g_grant, n_exp;
   logic [AW-1:0] e_addr [8];
   int e_slot [8], e_len [8];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   function automatic int min2(int a, int b);
      return (a < b) ? a : b;
   endfunction

   // R4/R5 expected burst list
   task automatic plan_bursts(input logic [IW-1:0] hstart, input int lstart);
      int hd = 1 << host_log2;
      int hp = int'(hstart), lp = lstart, rp = g_pend, rg = g_grant;
      n_exp = 0;
      while (rg > 0 && n_exp < 8) begin
         int hs = hp % hd;
         int len = min2(min2(hd - hs, LDEPTH - lp), min2(rp, rg));
         e_addr[n_exp] = BASE + AW'(hs * PKT_BYTES);
         e_slot[n_exp] = lp;
         e_len[n_exp]  = len;
         n_exp++;
         hp += len; lp = (lp + len) % LDEPTH; rp -= len; rg -= len;
      end
   endtask

   task automatic wait_alloc(input int cap, input string req);
      int t = 0;
      logic [IW-1:0] old;
      int freeslots, lstart;
      while (!alloc_req && t < 30) begin @(negedge clk); t++; end
      chk(alloc_req, req, "alloc_req seen", alloc_req, 1);
      if (!alloc_req) return;
      g_pend = int'(IW'(host_wr_idx - m_hrd));
      chk(alloc_cnt == IW'(g_pend), "R3", "alloc_cnt", alloc_cnt, g_pend);
      freeslots = LDEPTH - int'(IW'(m_lwr - m_lrd));
      g_grant = min2(min2(g_pend, freeslots), cap);
      lstart = int'(m_lwr) % LDEPTH;
      m_lwr = m_lwr + IW'(g_grant);
      alloc_grant = IW'(g_grant);
      alloc_wr_slot = m_lwr[LAW-1:0];
      old = m_hrd;
      @(negedge clk);
      alloc_grant = '0;
      chk(!alloc_req, "R3", "alloc_req one cycle", alloc_req, 0);
      m_hrd = m_hrd + IW'(g_grant);
      chk(host_rd_idx == m_hrd, "R3", "host_rd_idx", host_rd_idx, m_hrd);
      plan_bursts(old, lstart);
      if (g_grant == 0) begin
         chk(stalled, "R6", "stalled on zero grant", stalled, 1);
         repeat (3) begin
            @(negedge clk);
            chk(!rd_valid, "R6", "no burst on zero grant", rd_valid, 0);
         end
      end else begin
         chk(rd_valid, "R6", "burst after grant", rd_valid, 1);
      end
   endtask

   task automatic take_bursts();
      int i = 0, t = 0;
      while (i < n_exp && t < 200) begin
         if (rd_valid) begin
            rd_ready = ($urandom % 10) < 7;
            if (rd_ready) begin
               chk(rd_len == IW'(e_len[i]), "R5", "burst len", rd_len, e_len[i]);
               chk(rd_slot == LAW'(e_slot[i]), (i == 0) ? "R4" : "R5",
                   "burst slot", rd_slot, e_slot[i]);
               chk(rd_host_addr == e_addr[i], "R5", "burst addr",
                   rd_host_addr, e_addr[i]);
               i++;
            end
         end else rd_ready = 1'b0;
         @(negedge clk);
         t++;
      end
      rd_ready = 1'b0;
      chk(i == n_exp, "R5", "burst count", i, n_exp);
      chk(!rd_valid, "R5", "no extra burst", rd_valid, 0);
      chk(stalled == (g_grant < g_pend), "R6", "stalled after series",
          stalled, g_grant < g_pend);
   endtask

   task automatic give_rsps(input bit no_alloc);
      for (int k = 0; k < n_exp; k++) begin
         repeat ($urandom % 3) begin
            @(negedge clk);
            if (no_alloc) chk(!alloc_req, "R8", "held during series", alloc_req, 0);
         end
         rsp_valid = 1'b1;
         @(negedge clk);
         rsp_valid = 1'b0;
         chk(done_wake == (k == n_exp - 1), "R7", "wake timing",
             done_wake, k == n_exp - 1);
         if (no_alloc) chk(!alloc_req, "R8", "held during series", alloc_req, 0);
      end
      @(negedge clk);
      chk(!done_wake, "R7", "wake single pulse", done_wake, 0);
   endtask

   task automatic fetch_cycle(input int cap, input bit use_req);
      if (use_req) begin
         fetch_req = 1'b1;
         @(negedge clk);
         fetch_req = 1'b0;
      end
      wait_alloc(cap, use_req ? "R3" : "R9");
      if (g_grant > 0) begin
         take_bursts();
         give_rsps(1'b0);
      end
   endtask

   task automatic retire(input int k, input bit hold, input bit expect_kick);
      m_lrd = m_lrd + IW'(k);
      if (hold) wb_ready = 1'b0;
      local_rd_adv = 1'b1;
      local_rd_new = m_lrd;
      @(negedge clk);
      local_rd_adv = 1'b0;
      chk(wb_valid, "R10", "wb_valid", wb_valid, 1);
      chk(wb_data == m_lrd, "R10", "wb_data", wb_data, m_lrd);
      chk(wb_addr == RDPTR, "R10", "wb_addr", wb_addr, RDPTR);
      if (hold) begin
         repeat (2) begin
            @(negedge clk);
            chk(wb_valid && wb_data == m_lrd, "R10", "wb held", wb_valid, 1);
         end
         wb_ready = 1'b1;
         @(negedge clk);
         chk(!wb_valid, "R10", "wb drops after accept", wb_valid, 0);
      end
      if (!expect_kick) begin
         repeat (3) begin
            @(negedge clk);
            chk(!alloc_req, "R11", "no fetch on idle retire", alloc_req, 0);
         end
      end
   endtask

   task automatic drain();
      while (host_wr_idx != m_hrd) begin
         if (m_lwr != m_lrd) begin
            retire(int'(IW'(m_lwr - m_lrd)), 1'b0, 1'b1);
            fetch_cycle(8, 1'b0);
         end else fetch_cycle(8, 1'b1);
      end
      if (m_lwr != m_lrd) retire(int'(IW'(m_lwr - m_lrd)), 1'b0, 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!rd_valid && !alloc_req && !wb_valid && !done_wake && !stalled,
          "R1", "outputs idle", {rd_valid, alloc_req, wb_valid, done_wake, stalled}, 0);
      chk(host_rd_idx == '0, "R1", "host_rd_idx", host_rd_idx, 0);

      // R2: nothing pending
      fetch_req = 1'b1; @(negedge clk); fetch_req = 1'b0;
      repeat (6) begin
         @(negedge clk);
         chk(!alloc_req, "R2", "no alloc when empty", alloc_req, 0);
      end

      // host depth 4: single burst, then held write-back with no refetch
      host_log2 = HLW'(2);
      host_wr_idx = 16'd3;
      fetch_cycle(8, 1'b1);
      retire(3, 1'b1, 1'b0);

      // host wrap, then R8 request during series, then local wrap
      host_wr_idx = 16'd7;
      fetch_req = 1'b1; @(negedge clk); fetch_req = 1'b0;
      wait_alloc(8, "R3");
      take_bursts();
      host_wr_idx = 16'd9;
      fetch_req = 1'b1; @(negedge clk); fetch_req = 1'b0;
      chk(!alloc_req, "R8", "no alloc while busy", alloc_req, 0);
      give_rsps(1'b1);
      wait_alloc(8, "R8");
      take_bursts();
      give_rsps(1'b0);

      // R6 zero grant, then R9 retire restarts with partial grant
      host_wr_idx = 16'd13;
      fetch_cycle(0, 1'b1);
      retire(2, 1'b0, 1'b1);
      wait_alloc(1, "R9");
      take_bursts();
      give_rsps(1'b0);
      chk(stalled, "R6", "stalled after short grant", stalled, 1);
      drain();

      // R11: host index moved without a request, retire kicks a fetch
      host_wr_idx = host_wr_idx + 16'd2;
      fetch_cycle(1, 1'b1);
      host_wr_idx = host_wr_idx + 16'd1;
      retire(int'(IW'(m_lwr - m_lrd)), 1'b0, 1'b1);
      wait_alloc(8, "R11");
      take_bursts();
      give_rsps(1'b0);
      drain();

      // constrained random series
      for (int it = 0; it < 40; it++) begin
         host_log2 = HLW'(2 + $urandom % 3);
         host_wr_idx = host_wr_idx + IW'(1 + $urandom % (1 << host_log2));
         fetch_cycle(1 + $urandom % 8, 1'b1);
         drain();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule